// File: doc/BRIEF.md
# Programmable Pattern Bit-Error-Rate Tester

This block is a per-port error-rate test engine. It is made of a pattern source and a pattern checker, and software configures both. The source produces one of two kinds of sequence. The first is a pseudo-random sequence from a two-tap feedback recurrence whose length `n` and inner tap `y` are set at run time, up to 32 stages. The second is a user word of 1 to 32 bits that repeats without gaps. The checker watches a receive stream and aligns itself to the same sequence. Once it is in sync, it counts the bits it inspects and the bits that disagree.

All data ports carry single-rail NRZ bits, and a shared `bit_en` strobe qualifies them. A direction control chooses where the engine sits. When `dir_sys` is 0, the source drives the line transmit output and the checker listens to the line receive input. When `dir_sys` is 1, the source drives the system-side receive output and the checker listens to the system-side transmit input. When the source is disabled, traffic passes straight through in both directions. The checker runs at all times. Its counters are read through a latch-and-clear strobe.

Top module: `prbs_bert`

## Requirements
- R1: In pseudo-random mode with a valid tap pair, every bit the source emits equals the XOR of the bits it emitted `n` and `y` strobes earlier. The source never settles into an all-zero run, because an all-zero feedback register is forced to hold a one.
- R2: In repeat mode, the source emits `rep_pat[0]` first and then the bits in ascending order. The length is `rep_len_m1 + 1`, and the pattern restarts without a gap.
- R3: The pseudo-random configuration is invalid when `n = 0`, `n > 32`, `y = 0` or `y >= n`. While it is invalid, `cfg_err` is 1, the source output is 0 and the checker stays out of sync.
- R4: While `gen_en` is 0, `line_tx_bit` follows `sys_tx_bit` and `sys_rx_bit` follows `line_rx_bit`.
- R5: With `gen_en` = 1 and `dir_sys` = 1, the sequence appears on `sys_rx_bit`, `line_tx_bit` follows `sys_tx_bit`, and the checker takes its bits from `sys_tx_bit`.
- R6: The checker runs whatever the value of `gen_en`. It seeds its reference from received bits and raises `in_sync` after 32 consecutive correct predictions. In pseudo-random mode, a prediction made from an all-zero reference does not count.
- R7: In repeat mode, the checker slips its phase on each mismatch while hunting. It reaches sync on the programmed pattern at any starting phase, and never reaches sync on a different periodic word.
- R8: In sync, a sixth mismatch inside one 64-bit observation block drops `in_sync`, and acquisition restarts from scratch. Fewer mismatches keep sync.
- R9: The bit counter advances once per strobe only while in sync. `cnt_latch` copies both counters to `bit_count` and `err_count` and clears them. Without `cnt_latch`, the two outputs hold their values.
- R10: Both counters saturate at their all-ones value.
- R11: A single flipped bit in the received stream, while in sync, adds exactly one to the error count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe that qualifies one bit on every data input |
| gen_en | input | 1 | Enables the pattern source |
| dir_sys | input | 1 | 0: line side, 1: system side |
| pat_mode | input | 1 | 0: pseudo-random, 1: repeating word |
| poly_n | input | $clog2(W)+1 | Feedback length n |
| poly_y | input | $clog2(W)+1 | Inner tap y |
| rep_pat | input | W | Repeating word, bit 0 sent first |
| rep_len_m1 | input | $clog2(W) | Repeating word length minus one |
| cnt_latch | input | 1 | Latch-and-clear strobe for both counters |
| sys_tx_bit | input | 1 | Traffic from the system toward the line |
| line_rx_bit | input | 1 | Traffic from the line receiver |
| line_tx_bit | output | 1 | Bit toward the line transmitter |
| sys_rx_bit | output | 1 | Bit toward the system |
| cfg_err | output | 1 | Invalid pseudo-random configuration |
| in_sync | output | 1 | Checker locked |
| bit_count | output | CNT_W | Latched count of bits inspected in sync |
| err_count | output | CNT_W | Latched count of mismatched bits |

## Verification
A corrupted source register shows up within `n` strobes, as a transmitted bit that breaks the recurrence. A stray zero in that register would show up as a run of zeros on the transmit output. A corrupted checker reference appears on the very next strobe as a counted error, and repeated corruption drops `in_sync` inside one 64-bit block. A wrong phase or run counter shows up either as sync declared too early, before 32 strobes, or as sync never reached on a clean stream. The bench therefore checks sync at a point that is too early and again at a point that is safely late.

// File: rtl/bert_pkg.sv
package bert_pkg;
    typedef enum logic {
        DET_HUNT = 1'b0,
        DET_LOCK = 1'b1
    } det_state_e;
endpackage

// File: rtl/bert_gen.sv
module bert_gen #(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  rep_mode,
    input  logic                  invalid,
    input  logic [$clog2(W):0]    n,
    input  logic [$clog2(W):0]    y,
    input  logic [W-1:0]          pat,
    input  logic [$clog2(W)-1:0]  plen,
    output logic                  gen_bit
);
    localparam int PW = $clog2(W);
    localparam int LW = PW + 1;

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [PW-1:0] idx;
        logic          bit_v;
    } gen_t;

    gen_t q, d;
    logic [W-1:0] mask, seed, sh_n, sh_y;
    logic fb;

    always_comb begin
        d    = q;
        mask = (n >= LW'(W)) ? '1 : ((W'(1) << n) - W'(1));
        // an all-zero live register is revived with a one
        seed = ((q.sr & mask) == '0) ? (q.sr | W'(1)) : q.sr;
        sh_n = seed >> (n - LW'(1));
        sh_y = seed >> (y - LW'(1));
        fb   = sh_n[0] ^ sh_y[0];
        if (invalid) begin
            d.bit_v = 1'b0;
        end else if (step) begin
            if (rep_mode) begin
                d.bit_v = pat[q.idx];
                d.idx   = (q.idx >= plen) ? '0 : q.idx + PW'(1);
            end else begin
                d.sr    = {seed[W-2:0], fb};
                d.bit_v = fb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sr: '1, idx: '0, bit_v: 1'b0};
        else        q <= d;
    end

    assign gen_bit = q.bit_v;
endmodule

// File: rtl/bert_det.sv
module bert_det
    import bert_pkg::*;
#(
    parameter int W        = 32,
    parameter int SYNC_RUN = 32,
    parameter int LOS_WIN  = 64,
    parameter int LOS_THR  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  rx_bit,
    input  logic                  rep_mode,
    input  logic                  invalid,
    input  logic [$clog2(W):0]    n,
    input  logic [$clog2(W):0]    y,
    input  logic [W-1:0]          pat,
    input  logic [$clog2(W)-1:0]  plen,
    output logic                  locked,
    output logic                  bit_inc,
    output logic                  err_inc
);
    localparam int PW = $clog2(W);
    localparam int LW = PW + 1;
    localparam int RW = $clog2(SYNC_RUN + 1);
    localparam int WW = $clog2(LOS_WIN);
    localparam int MW = $clog2(LOS_THR + 1);

    typedef struct packed {
        det_state_e    st;
        logic [W-1:0]  sr;
        logic [PW-1:0] ph;
        logic [RW-1:0] run;
        logic [WW-1:0] win;
        logic [MW-1:0] wmis;
    } det_t;

    det_t q, d;
    logic [W-1:0]  mask, sh_n, sh_y;
    logic [PW-1:0] ph_nx;
    logic pred, mis, zero_ref;

    always_comb begin
        d        = q;
        bit_inc  = 1'b0;
        err_inc  = 1'b0;
        mask     = (n >= LW'(W)) ? '1 : ((W'(1) << n) - W'(1));
        sh_n     = q.sr >> (n - LW'(1));
        sh_y     = q.sr >> (y - LW'(1));
        pred     = rep_mode ? pat[q.ph] : (sh_n[0] ^ sh_y[0]);
        zero_ref = !rep_mode && ((q.sr & mask) == '0);
        mis      = rx_bit ^ pred;
        ph_nx    = (q.ph >= plen) ? '0 : q.ph + PW'(1);
        if (invalid) begin
            d.st  = DET_HUNT;
            d.run = '0;
        end else if (step) begin
            if (q.st == DET_HUNT) begin
                d.sr = {q.sr[W-2:0], rx_bit};
                if (mis || zero_ref) begin
                    d.run = '0;              // repeat mode: phase stays, i.e. slips
                end else begin
                    d.ph = ph_nx;
                    if (q.run == RW'(SYNC_RUN - 1)) begin
                        d.st   = DET_LOCK;
                        d.run  = '0;
                        d.win  = '0;
                        d.wmis = '0;
                    end else begin
                        d.run = q.run + RW'(1);
                    end
                end
            end else begin
                bit_inc = 1'b1;
                err_inc = mis;
                d.sr    = {q.sr[W-2:0], pred};   // free-running reference
                d.ph    = ph_nx;
                if (mis && (q.wmis == MW'(LOS_THR - 1))) begin
                    d.st  = DET_HUNT;
                    d.run = '0;
                end else if (q.win == WW'(LOS_WIN - 1)) begin
                    d.win  = '0;
                    d.wmis = '0;
                end else begin
                    d.win  = q.win + WW'(1);
                    d.wmis = q.wmis + MW'(mis);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: DET_HUNT, sr: '0, ph: '0, run: '0, win: '0, wmis: '0};
        else        q <= d;
    end

    assign locked = (q.st == DET_LOCK);
endmodule

// File: rtl/bert_cnt.sv
module bert_cnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          latch,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [CW-1:0] acc;
        logic [CW-1:0] shown;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        if (latch) begin
            d.shown = q.acc;
            d.acc   = CW'(inc);
        end else if (q.acc != '1) begin
            d.acc = q.acc + CW'(inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.shown;
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert #(
    parameter int W        = 32,
    parameter int CNT_W    = 32,
    parameter int SYNC_RUN = 32,
    parameter int LOS_WIN  = 64,
    parameter int LOS_THR  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  gen_en,
    input  logic                  dir_sys,
    input  logic                  pat_mode,
    input  logic [$clog2(W):0]    poly_n,
    input  logic [$clog2(W):0]    poly_y,
    input  logic [W-1:0]          rep_pat,
    input  logic [$clog2(W)-1:0]  rep_len_m1,
    input  logic                  cnt_latch,
    input  logic                  sys_tx_bit,
    input  logic                  line_rx_bit,
    output logic                  line_tx_bit,
    output logic                  sys_rx_bit,
    output logic                  cfg_err,
    output logic                  in_sync,
    output logic [CNT_W-1:0]      bit_count,
    output logic [CNT_W-1:0]      err_count
);
    localparam int LW = $clog2(W) + 1;

    typedef struct packed {
        logic cfg_err;
    } top_t;

    top_t q, d;
    logic invalid, gen_bit, det_rx, bit_inc, err_inc;

    always_comb begin
        invalid = !pat_mode && ((poly_n == '0) || (poly_n > LW'(W)) ||
                                (poly_y == '0) || (poly_y >= poly_n));
        d.cfg_err = invalid;
        det_rx      = dir_sys ? sys_tx_bit : line_rx_bit;
        line_tx_bit = (gen_en && !dir_sys) ? gen_bit : sys_tx_bit;
        sys_rx_bit  = (gen_en &&  dir_sys) ? gen_bit : line_rx_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_err = q.cfg_err;

    bert_gen #(.W(W)) i_gen (
        .clk(clk), .rst_n(rst_n), .step(bit_en && gen_en), .rep_mode(pat_mode),
        .invalid(invalid), .n(poly_n), .y(poly_y), .pat(rep_pat), .plen(rep_len_m1),
        .gen_bit(gen_bit)
    );

    bert_det #(.W(W), .SYNC_RUN(SYNC_RUN), .LOS_WIN(LOS_WIN), .LOS_THR(LOS_THR)) i_det (
        .clk(clk), .rst_n(rst_n), .step(bit_en), .rx_bit(det_rx), .rep_mode(pat_mode),
        .invalid(invalid), .n(poly_n), .y(poly_y), .pat(rep_pat), .plen(rep_len_m1),
        .locked(in_sync), .bit_inc(bit_inc), .err_inc(err_inc)
    );

    bert_cnt #(.CW(CNT_W)) i_bits (
        .clk(clk), .rst_n(rst_n), .inc(bit_inc), .latch(cnt_latch), .count(bit_count)
    );

    bert_cnt #(.CW(CNT_W)) i_errs (
        .clk(clk), .rst_n(rst_n), .inc(err_inc), .latch(cnt_latch), .count(err_count)
    );
endmodule

// File: rtl/bert_chk.sv
module bert_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             gen_en,
    input logic             dir_sys,
    input logic             cnt_latch,
    input logic             line_tx_bit,
    input logic             cfg_err,
    input logic             in_sync,
    input logic [CNT_W-1:0] bit_count,
    input logic [CNT_W-1:0] err_count
);
    p_mute_on_cfg_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && gen_en && !dir_sys) |-> !line_tx_bit);

    p_no_sync_on_cfg_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !in_sync);

    p_counts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_latch |=> ($stable(bit_count) && $stable(err_count)));

    p_sync_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(bit_en));

    p_errs_within_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_latch |=> (err_count <= bit_count));
endmodule

bind prbs_bert bert_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_prbs_bert.sv
module test_prbs_bert;
    localparam int W   = 32;
    localparam int CW  = 8;

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, gen_en = 1'b0, dir_sys = 1'b0;
    logic pat_mode = 1'b0, cnt_latch = 1'b0, sys_tx_bit = 1'b0, line_rx_bit = 1'b0;
    logic [5:0] poly_n = 6'd7, poly_y = 6'd6;
    logic [W-1:0] rep_pat = '0;
    logic [4:0] rep_len_m1 = '0;
    logic line_tx_bit, sys_rx_bit, cfg_err, in_sync;
    logic [CW-1:0] bit_count, err_count;

    int checks = 0, failures = 0;
    logic [31:0] mdl;
    int mn, my;

    always #5 clk = ~clk;

    prbs_bert #(.W(W), .CNT_W(CW)) i_prbs_bert (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .gen_en(gen_en), .dir_sys(dir_sys),
        .pat_mode(pat_mode), .poly_n(poly_n), .poly_y(poly_y), .rep_pat(rep_pat),
        .rep_len_m1(rep_len_m1), .cnt_latch(cnt_latch), .sys_tx_bit(sys_tx_bit),
        .line_rx_bit(line_rx_bit), .line_tx_bit(line_tx_bit), .sys_rx_bit(sys_rx_bit),
        .cfg_err(cfg_err), .in_sync(in_sync), .bit_count(bit_count), .err_count(err_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic lrx, input logic stx);
        @(negedge clk);
        line_rx_bit = lrx; sys_tx_bit = stx; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic latch();
        @(negedge clk); cnt_latch = 1'b1;
        @(negedge clk); cnt_latch = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ref_bit(output logic b);
        b = mdl[mn-1] ^ mdl[my-1];
        mdl = {mdl[30:0], b};
    endtask

    task automatic ref_start(input int n, input int y);
        mn = n; my = y; mdl = '1;
        poly_n = 6'(n); poly_y = 6'(y);
    endtask

    task automatic t_reset();
        chk(in_sync == 1'b0, "R6 reset sync", in_sync, 0);
        chk(bit_count == '0 && err_count == '0, "R9 reset counts", bit_count, 0);
        chk(cfg_err == 1'b0, "R3 reset cfg_err", cfg_err, 0);
    endtask

    task automatic t_pass();
        gen_en = 1'b0;
        for (int d = 0; d < 2; d++) begin
            dir_sys = d[0];
            for (int v = 0; v < 4; v++) begin
                step(v[0], v[1]);
                chk(line_tx_bit == v[1] && sys_rx_bit == v[0], "R4 pass-through",
                    {line_tx_bit, sys_rx_bit}, {v[1], v[0]});
            end
        end
        dir_sys = 1'b0;
    endtask

    task automatic t_prbs_gen();
        logic seq [0:99];
        int ns [2] = '{7, 9};
        int ys [2] = '{6, 5};
        pat_mode = 1'b0; gen_en = 1'b1; dir_sys = 1'b0;
        for (int c = 0; c < 2; c++) begin
            int bad = 0, ones = 0;
            poly_n = 6'(ns[c]); poly_y = 6'(ys[c]);
            for (int k = 0; k < 100; k++) begin
                step(1'b0, 1'b0);
                seq[k] = line_tx_bit;
                ones += int'(seq[k]);
            end
            for (int k = ns[c]; k < 100; k++)
                if (seq[k] != (seq[k-ns[c]] ^ seq[k-ys[c]])) bad++;
            chk(bad == 0, "R1 recurrence", bad, 0);
            chk(ones > 0, "R1 not stuck at zero", ones, 1);
        end
    endtask

    task automatic t_repeat_gen();
        int bad;
        pat_mode = 1'b1; gen_en = 1'b1;
        rep_pat = 32'hA5A5_A5B6; rep_len_m1 = 5'd4;   // low five bits 10110
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            step(1'b0, 1'b0);
            if (line_tx_bit != rep_pat[k % 5]) bad++;
        end
        chk(bad == 0, "R2 five-bit word", bad, 0);
        rep_pat = 32'h0000_0001; rep_len_m1 = 5'd0;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            step(1'b0, 1'b0);
            if (line_tx_bit != 1'b1) bad++;
        end
        chk(bad == 0, "R2 one-bit word", bad, 0);
        rep_pat = 32'h8000_0C01; rep_len_m1 = 5'd31;
        bad = 0;
        for (int k = 0; k < 64; k++) begin
            step(1'b0, 1'b0);
            if (line_tx_bit != rep_pat[k % 32]) bad++;
        end
        chk(bad == 0, "R2 32-bit word", bad, 0);
        pat_mode = 1'b0;
    endtask

    task automatic t_invalid_gen();
        int ns [4] = '{5, 4, 0, 40};
        int ys [4] = '{5, 0, 0, 3};
        gen_en = 1'b1; dir_sys = 1'b0; pat_mode = 1'b0;
        for (int c = 0; c < 4; c++) begin
            int ones = 0;
            poly_n = 6'(ns[c]); poly_y = 6'(ys[c]);
            for (int k = 0; k < 4; k++) begin
                step(1'b0, 1'b1);
                ones += int'(line_tx_bit);
            end
            chk(cfg_err == 1'b1, "R3 cfg_err raised", cfg_err, 1);
            chk(ones == 0, "R3 output held at 0", ones, 0);
        end
        poly_n = 6'd7; poly_y = 6'd6;
        step(1'b0, 1'b0);
        chk(cfg_err == 1'b0, "R3 cfg_err cleared", cfg_err, 0);
    endtask

    task automatic t_dir1();
        logic seq [0:79];
        int bad = 0, rbad = 0;
        logic b;
        gen_en = 1'b1; dir_sys = 1'b1; pat_mode = 1'b0;
        ref_start(7, 6);
        for (int k = 0; k < 80; k++) begin
            ref_bit(b);
            step(k[0], b);
            seq[k] = sys_rx_bit;
            if (line_tx_bit != b) bad++;
        end
        for (int k = 7; k < 80; k++)
            if (seq[k] != (seq[k-7] ^ seq[k-6])) rbad++;
        chk(bad == 0, "R5 line_tx follows sys_tx", bad, 0);
        chk(rbad == 0, "R5 sequence on sys_rx", rbad, 0);
        chk(in_sync == 1'b1, "R5 detector on sys_tx", in_sync, 1);
        dir_sys = 1'b0; gen_en = 1'b0;
    endtask

    task automatic t_sync_acq();
        logic b;
        gen_en = 1'b0; dir_sys = 1'b0; pat_mode = 1'b0;
        ref_start(15, 14);
        for (int k = 0; k < 31; k++) begin ref_bit(b); step(b, 1'b0); end
        chk(in_sync == 1'b0, "R6 no sync before 32 matches", in_sync, 0);
        for (int k = 0; k < 39; k++) begin ref_bit(b); step(b, 1'b0); end
        chk(in_sync == 1'b1, "R6 sync with generator off", in_sync, 1);
    endtask

    task automatic t_counters();
        logic b;
        latch();
        for (int k = 0; k < 100; k++) begin
            ref_bit(b);
            step(b ^ (k == 10 || k == 45 || k == 80), 1'b0);
        end
        latch();
        chk(bit_count == CW'(100), "R9 bit count", bit_count, 100);
        chk(err_count == CW'(3), "R11 one count per error", err_count, 3);
        chk(in_sync == 1'b1, "R8 sparse errors keep sync", in_sync, 1);
    endtask

    task automatic t_sat();
        logic b;
        latch();
        for (int k = 0; k < 300; k++) begin ref_bit(b); step(b, 1'b0); end
        latch();
        chk(bit_count == '1, "R10 bit count saturates", bit_count, 255);
        chk(err_count == '0, "R10 clean run no errors", err_count, 0);
    endtask

    task automatic t_los();
        logic b;
        for (int k = 0; k < 20; k++) begin ref_bit(b); step(~b, 1'b0); end
        chk(in_sync == 1'b0, "R8 loss after burst", in_sync, 0);
        for (int k = 0; k < 70; k++) begin ref_bit(b); step(b, 1'b0); end
        chk(in_sync == 1'b1, "R8 reacquire", in_sync, 1);
    endtask

    task automatic t_invalid_det();
        poly_y = 6'd15;
        repeat (2) @(negedge clk);
        chk(in_sync == 1'b0 && cfg_err == 1'b1, "R3 detector out of sync",
            {in_sync, cfg_err}, 1);
        poly_y = 6'd14;
    endtask

    task automatic t_zero();
        ref_start(15, 14);
        for (int k = 0; k < 100; k++) step(1'b0, 1'b0);
        chk(in_sync == 1'b0, "R6 all-zero stream no sync", in_sync, 0);
    endtask

    task automatic t_repeat_det();
        logic [4:0] wrong = 5'b00111;   // sent bit 0 first: 1,1,1,0,0
        pat_mode = 1'b1; gen_en = 1'b0; dir_sys = 1'b0;
        rep_pat = 32'h0000_0016; rep_len_m1 = 5'd4;
        for (int k = 0; k < 200; k++) step(wrong[k % 5], 1'b0);
        chk(in_sync == 1'b0, "R7 other word no sync", in_sync, 0);
        for (int k = 0; k < 80; k++) step(rep_pat[(k + 2) % 5], 1'b0);
        chk(in_sync == 1'b1, "R7 sync at offset phase", in_sync, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_pass();
        t_prbs_gen();
        t_repeat_gen();
        t_invalid_gen();
        t_dir1();
        do_reset();
        t_sync_acq();
        t_counters();
        t_sat();
        t_los();
        t_invalid_det();
        do_reset();
        t_zero();
        t_repeat_det();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule